// File: doc/BRIEF.md
# Gated Engine Tachometer Counter

This block turns a frequency-multiplied ignition pulse stream into an engine speed reading. The multiplier ahead of it (not part of this block) scales the ignition rate by a factor that depends on the number of cylinders. Because the multiplier is matched to the counting window, the number of pulses counted in one fixed gate of a third of a second equals the engine speed in RPM. The block synchronises the pulse stream and counts its rising edges. It accepts an edge only while the multiplier reports lock. Each edge, or each tenth edge in the high range, advances a three-decade BCD counter. At the end of every gate the block copies the counter into a display register and raises a one-cycle strobe.

The gate length is the only adjustment. It is a parameter in clock cycles and should equal the clock frequency divided by three. The block also reports the multiplier that belongs to the selected cylinder code. Changing the cylinder code or the range in the middle of a gate throws that gate away and starts a fresh one, so a reading never mixes two settings.

Top module: `eng_tach_meter`

## Requirements
- R1: `mult_o` reports the active multiplier for `cyl_sel`: code 0 (4 cylinders) gives 90, code 1 (6 cylinders) gives 60, code 2 (8 cylinders) gives 45 and code 3 gives 0.
- R2: With the selection held steady, a gate lasts exactly `GATE_CYCLES` clock cycles, and `valid_o` is high for one cycle after each gate ends.
- R3: `pulse_in` passes through a two-flop synchroniser and counts once per rising edge, however long it stays high.
- R4: A rising edge detected while `lock_in` is low is not counted.
- R5: When `range_hi` is 0, each accepted edge adds one to the reading (0 to 999 RPM).
- R6: When `range_hi` is 1, one count is added per ten accepted edges (0 to 9990 RPM in steps of 10). The divide-by-ten state clears at every gate start and on every range change.
- R7: `digits_o` holds three BCD digits: hundreds in [11:8], tens in [7:4] and units in [3:0]. It changes only together with `valid_o`.
- R8: A count past 999 wraps the counter and sets an overflow flag. `ovf_o` is reported with that gate's reading, and the flag clears for the next gate.
- R9: A change of `cyl_sel` or `range_hi` aborts the running gate. No reading is issued for that gate, its counts are discarded, and a full new gate begins in the cycle of the change.
- R10: An edge detected in the cycle a gate restarts is not counted in either gate.
- R11: Under reset, `digits_o` is 0, `ovf_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_in | input | 1 | Multiplied pulse stream, asynchronous |
| lock_in | input | 1 | Lock flag from the multiplier; pulses are counted only while it is high |
| cyl_sel | input | 2 | Cylinder code: 0 = 4, 1 = 6, 2 = 8 cylinders |
| range_hi | input | 1 | 1 selects the divided-by-ten high range |
| digits_o | output | 4*DIGITS (12) | Latched BCD reading |
| ovf_o | output | 1 | Overflow of the latched reading |
| valid_o | output | 1 | One-cycle strobe when a new reading is latched |
| mult_o | output | 7 | Multiplier for the selected cylinder code |

## Verification
Two functions can fall in the same cycle. A detected pulse edge can coincide with the gate restart, and a selection change can coincide with the natural end of a gate. The bench times a rising edge so that it is detected exactly on the restart edge. It then expects the finished reading to leave that edge out and the next gate to read zero. A behavioural model that runs on every clock judges every cycle of these collisions, as well as the abort and wrap cases, against the outputs.

// File: rtl/tach_pkg.sv
// Shared types and helpers for the tachometer counter.
// Assumes four-bit BCD decades and a two-bit cylinder code.
package tach_pkg;
    localparam int BCD_W  = 4;
    localparam int MULT_W = 7;

    typedef logic [BCD_W-1:0] bcd_t;

    // Multiplier reported for each cylinder code; unused code reports 0.
    function automatic logic [MULT_W-1:0] mult_for(input logic [1:0] code);
        case (code)
            2'd0:    mult_for = MULT_W'(90);
            2'd1:    mult_for = MULT_W'(60);
            2'd2:    mult_for = MULT_W'(45);
            default: mult_for = '0;
        endcase
    endfunction
endpackage

// File: rtl/tach_edge_sync.sv
// Synchronises an asynchronous pulse into clk and flags its rising edge.
// Assumes the pulse stays high and low for at least one clock each.
module tach_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    // Shift the input through the sync chain plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tach_gate_timer.sv
// Counts the gate interval in clock cycles and flags its final cycle.
// Assumes CYCLES >= 2; an abort restarts the interval from zero.
module tach_gate_timer #(
    parameter int CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    output logic gate_end
);
    localparam int GW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [GW-1:0] LAST = GW'(CYCLES - 1);

    logic [GW-1:0] cnt_q;

    assign gate_end = (cnt_q == LAST);

    // Advance the gate position, wrapping at the end or on abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (abort | gate_end) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tach_prescaler.sv
// Optional divide-by-DIV stage ahead of the decade counter.
// Assumes clr takes priority; in bypass every input pulse passes.
module tach_prescaler #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bypass,
    input  logic pulse,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pc_q;

    assign tick = bypass ? pulse : (pulse && pc_q == LAST);

    // Count pulses modulo DIV while the divider is in use.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pc_q <= '0;
        else if (clr)               pc_q <= '0;
        else if (!bypass && pulse)  pc_q <= (pc_q == LAST) ? '0 : pc_q + 1'b1;
    end
endmodule

// File: rtl/tach_bcd_counter.sv
// Cascaded BCD decades; carry_out pulses when all decades wrap together.
// Assumes clr has priority over inc.
module tach_bcd_counter
    import tach_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    inc,
    output logic [BCD_W*DIGITS-1:0] value,
    output logic                    carry_out
);
    logic [DIGITS:0] cy;

    assign cy[0]     = inc;
    assign carry_out = cy[DIGITS];

    for (genvar i = 0; i < DIGITS; i++) begin : g_dec
        bcd_t d_q;

        assign cy[i+1] = cy[i] & (d_q == bcd_t'(9));
        assign value[i*BCD_W +: BCD_W] = d_q;

        // Step this decade when the carry from below arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)     d_q <= '0;
            else if (clr)   d_q <= '0;
            else if (cy[i]) d_q <= (d_q == bcd_t'(9)) ? '0 : d_q + 1'b1;
        end
    end
endmodule

// File: rtl/eng_tach_meter.sv
// Gated tachometer counter: counts locked, synchronised pulse edges over a
// fixed gate and latches a BCD reading with overflow at each gate end.
// Assumes GATE_CYCLES = clock frequency / 3 and pulse_in already multiplied.
module eng_tach_meter
    import tach_pkg::*;
#(
    parameter int GATE_CYCLES = 1_000_000,
    parameter int DIGITS      = 3,
    parameter int PRESCALE    = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pulse_in,
    input  logic                    lock_in,
    input  logic [1:0]              cyl_sel,
    input  logic                    range_hi,
    output logic [BCD_W*DIGITS-1:0] digits_o,
    output logic                    ovf_o,
    output logic                    valid_o,
    output logic [MULT_W-1:0]       mult_o
);
    localparam int DW = BCD_W * DIGITS;

    logic          rise, accept, tick, gate_end, restart, sel_chg;
    logic          carry, ovf_q;
    logic [2:0]    sel_q;
    logic [DW-1:0] count;

    assign mult_o  = mult_for(cyl_sel);
    assign sel_chg = ({cyl_sel, range_hi} != sel_q);
    assign restart = gate_end | sel_chg;
    assign accept  = rise & lock_in;

    tach_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pulse_in), .rise(rise)
    );

    tach_gate_timer #(.CYCLES(GATE_CYCLES)) u_gate (
        .clk(clk), .rst_n(rst_n), .abort(sel_chg), .gate_end(gate_end)
    );

    tach_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(restart), .bypass(~range_hi),
        .pulse(accept), .tick(tick)
    );

    tach_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(restart), .inc(tick),
        .value(count), .carry_out(carry)
    );

    // Remember the selection to detect a change mid-gate.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= {cyl_sel, range_hi};
    end

    // Sticky overflow for the running gate, cleared at every restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (restart) ovf_q <= 1'b0;
        else if (carry)   ovf_q <= 1'b1;
    end

    // Latch the reading at an undisturbed gate end and strobe valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digits_o <= '0;
            ovf_o    <= 1'b0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= gate_end & ~sel_chg;
            if (gate_end & ~sel_chg) begin
                digits_o <= count;
                ovf_o    <= ovf_q;
            end
        end
    end
endmodule

// File: rtl/tach_checker.sv
// Port-level properties of the tachometer counter, bound to every instance.
module tach_checker #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cyl_sel,
    input logic          range_hi,
    input logic [DW-1:0] digits_o,
    input logic          ovf_o,
    input logic          valid_o,
    input logic [6:0]    mult_o
);
    function automatic logic all_bcd(input logic [DW-1:0] v);
        all_bcd = 1'b1;
        for (int i = 0; i < DW / 4; i++)
            if (v[i*4 +: 4] > 4'd9) all_bcd = 1'b0;
    endfunction

    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r7_digits_bcd: assert property (@(posedge clk) disable iff (!rst_n)
        all_bcd(digits_o));

    a_r7_digits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(digits_o));

    a_r8_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(ovf_o));

    a_r9_abort_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cyl_sel != $past(cyl_sel) || range_hi != $past(range_hi)) |=> !valid_o);

    a_r1_mult_known: assert property (@(posedge clk) disable iff (!rst_n)
        (cyl_sel != 2'd3) |-> (mult_o == 7'd90 || mult_o == 7'd60 || mult_o == 7'd45));
endmodule

bind eng_tach_meter tach_checker #(.DW(tach_pkg::BCD_W * DIGITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyl_sel(cyl_sel), .range_hi(range_hi),
    .digits_o(digits_o), .ovf_o(ovf_o), .valid_o(valid_o), .mult_o(mult_o)
);

// File: tb/eng_tach_meter_tb.sv
module eng_tach_meter_tb;
    localparam int G = 2500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_in = 1'b0;
    logic        lock_in = 1'b1;
    logic [1:0]  cyl_sel = 2'd0;
    logic        range_hi = 1'b0;
    logic [11:0] digits_o;
    logic        ovf_o, valid_o;
    logic [6:0]  mult_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    eng_tach_meter #(.GATE_CYCLES(G)) u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .lock_in(lock_in),
        .cyl_sel(cyl_sel), .range_hi(range_hi), .digits_o(digits_o),
        .ovf_o(ovf_o), .valid_o(valid_o), .mult_o(mult_o)
    );

    always #5 clk = ~clk;

    function automatic logic [11:0] to_bcd(input int v);
        to_bcd = {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int mult_ref(input logic [1:0] c);
        case (c)
            2'd0: mult_ref = 90;
            2'd1: mult_ref = 60;
            2'd2: mult_ref = 45;
            default: mult_ref = 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Behavioural reference, updated on every clock.
    int   m_gate, m_pre, m_cnt, m_dig;
    bit   m_sticky, m_ovf, m_valid;
    bit   m_s1, m_s2, m_s3;
    logic [1:0] m_cyl;
    bit   m_rng;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_gate = 0; m_pre = 0; m_cnt = 0; m_dig = 0;
            m_sticky = 0; m_ovf = 0; m_valid = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cyl = 0; m_rng = 0;
        end else begin
            bit edge_seen, chg, gend, restart;
            edge_seen = m_s2 && !m_s3 && lock_in;
            chg  = (cyl_sel != m_cyl) || (range_hi != m_rng);
            gend = (m_gate == G - 1);
            restart = chg || gend;
            m_valid = gend && !chg;
            if (m_valid) begin
                m_dig = m_cnt;
                m_ovf = m_sticky;
            end
            if (restart) begin
                m_cnt = 0; m_pre = 0; m_sticky = 0;
            end else if (edge_seen) begin
                bit step;
                step = 1;
                if (range_hi) begin
                    m_pre++;
                    step = (m_pre == 10);
                    if (step) m_pre = 0;
                end
                if (step) begin
                    m_cnt++;
                    if (m_cnt == 1000) begin
                        m_cnt = 0;
                        m_sticky = 1;
                    end
                end
            end
            m_gate = restart ? 0 : m_gate + 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pulse_in;
            m_cyl = cyl_sel; m_rng = range_hi;
        end
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    // Compare every cycle against the model (R1, R2, R7, R8).
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 valid", int'(valid_o), int'(m_valid));
            check("R7 digits", int'(digits_o), int'(to_bcd(m_dig)));
            check("R8 ovf", int'(ovf_o), int'(m_ovf));
            check("R1 mult", int'(mult_o), mult_ref(cyl_sel));
        end
    end

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            pulse_in = 1'b1;
            repeat (hi) @(negedge clk);
            pulse_in = 1'b0;
            repeat (lo) @(negedge clk);
        end
    endtask

    task automatic wait_valid(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!valid_o);
    endtask

    task automatic expect_reading(input string req, input int rpm, input bit ov);
        int w;
        wait_valid(w);
        check(req, int'(digits_o), int'(to_bcd(rpm)));
        check(req, int'(ovf_o), int'(ov));
    endtask

    initial begin
        int w;
        repeat (4) @(negedge clk);
        check("R11 digits", int'(digits_o), 0);
        check("R11 ovf", int'(ovf_o), 0);
        check("R11 valid", int'(valid_o), 0);
        rst_n = 1'b1;

        // R1: multiplier per cylinder code
        for (int c = 0; c < 4; c++) begin
            cyl_sel = 2'(c);
            @(negedge clk);
            check("R1", int'(mult_o), mult_ref(2'(c)));
        end
        cyl_sel = 2'd0;
        wait_valid(w);

        pulses(37, 2, 2);                  // R5 low range direct count
        expect_reading("R5", 37, 0);

        pulses(5, 30, 10);                 // R3 long highs count once
        expect_reading("R3", 5, 0);

        lock_in = 1'b0;                    // R4 unlocked edges dropped
        pulses(20, 2, 2);
        lock_in = 1'b1;
        pulses(10, 2, 2);
        expect_reading("R4", 10, 0);

        range_hi = 1'b1;                   // R6 high range divides by ten
        wait_valid(w);
        pulses(95, 2, 2);
        expect_reading("R6", 9, 0);
        pulses(5, 2, 2);                   // R6 remainder cleared at gate start
        expect_reading("R6 prescaler clear", 0, 0);
        range_hi = 1'b0;
        wait_valid(w);

        pulses(1003, 1, 1);                // R8 wrap past 999
        expect_reading("R8 wrap", 3, 1);
        pulses(2, 2, 2);
        expect_reading("R8 cleared", 2, 0);

        pulses(10, 2, 2);                  // R9 abort mid-gate
        cyl_sel = 2'd1;
        wait_valid(w);
        check("R9 gate restarted", w, G + 1);
        check("R9 counts discarded", int'(digits_o), 0);

        pulses(3, 2, 2);                   // R10 edge on the restart cycle
        repeat (G - 15) @(negedge clk);
        pulse_in = 1'b1;
        expect_reading("R10 before", 3, 0);
        expect_reading("R10 after", 0, 0);
        pulse_in = 1'b0;
        repeat (5) @(negedge clk);

        finish_run();
    end
endmodule